// File: doc/BRIEF.md
# Receive Sample Serial Packer

This block turns parallel receive I/Q samples into a source-synchronous serial stream. Each input sample is a pair of 22-bit signed values (I and Q) plus an 8-bit gain word and a one-bit gain-change flag. The block packs them into serial words and sends them on one or two data lines, together with a strobe that marks the start of each word and a forwarded data clock.

Two formats are available. The wide format sends the unrounded 22-bit value with a zero bit, the gain-change flag and the gain word. The narrow format sends a 15-bit value rounded from the 22-bit one, followed by the gain-change flag. Two layouts are available. The two-lane layout carries I on line 0 and Q on line 1 at the same time. The one-lane layout sends both halves on line 0, one after the other.

The serial clock is an input and may run at 1, 2, 4 or 8 times the rate one word needs. At the faster rates, each word is sent once and the rest of the sample period stays silent. Samples are taken on a valid/ready handshake. Configuration is latched with each sample.

Top module: `rx_ssi_packer`

## Requirements
- R1: Wide format (`cfg_fmt15`=0), two lanes (`cfg_one_lane`=0): each lane sends a 32-bit word. From MSB to LSB the word is the 22-bit sample, a 0 bit, the gain-change flag, then gain[7:0]. I goes on `ser_d0` and Q goes on `ser_d1`.
- R2: Wide format, one lane: `ser_d0` sends a 64-bit word. The upper 32 bits hold the first half and the lower 32 bits hold the second half, each laid out as in R1. With `cfg_q_first`=0, I is first; with `cfg_q_first`=1, Q is first.
- R3: The 15-bit value is bits [21:7] of the sample plus bit [6], which rounds half up. When bits [21:7] equal 15'h3FFF, the result saturates at 15'h3FFF.
- R4: Narrow format (`cfg_fmt15`=1) uses 16-bit halves: the rounded value, then the gain-change flag as LSB. With two lanes, each lane sends its own 16-bit half. With one lane, a 32-bit word is sent: the first half in the upper 16 bits, ordered by `cfg_q_first` as in R2.
- R5: With `cfg_lsb_first`=0, each word is sent MSB first. With `cfg_lsb_first`=1, it is sent LSB first.
- R6: The strobe is active in bit slots of the sample period, with slot 0 holding the first bit. With `cfg_long_strobe`=0, the strobe is high in slot 0 only. With `cfg_long_strobe`=1, it is high in slots 0 to L/2-1, where L is the word length.
- R7: A sample period lasts L·2^`cfg_rate` slots (`cfg_rate` 0..3). Slots at or beyond L hold both data lines and the strobe low.
- R8: `in_ready` is high when no word is in progress, and in the last slot of a period. A sample offered in that last slot starts its slot 0 on the very next cycle.
- R9: When no word is in progress, `ser_d0`, `ser_d1` and `ser_strobe` are low.
- R10: In the one-lane layout, `ser_d1` stays low.
- R11: The configuration inputs are captured when a sample is accepted. Changing them during a word does not affect that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fmt15 | input | 1 | 1 selects the 15-bit rounded format |
| cfg_one_lane | input | 1 | 1 selects the one-lane layout |
| cfg_lsb_first | input | 1 | 1 sends each word LSB first |
| cfg_q_first | input | 1 | One-lane only: 1 sends Q before I |
| cfg_long_strobe | input | 1 | 1 selects the half-word strobe |
| cfg_rate | input | 2 | Clock multiple, as a power of two |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample will be taken at this edge |
| in_i | input | 22 | I sample |
| in_q | input | 22 | Q sample |
| in_gain | input | 8 | Gain word |
| in_gain_chg | input | 1 | Gain-change flag |
| ser_dclk | output | 1 | Forwarded data clock |
| ser_strobe | output | 1 | Word strobe |
| ser_d0 | output | 1 | Data line 0 (I, or both halves in one-lane layout) |
| ser_d1 | output | 1 | Data line 1 (Q in two-lane layout) |

## Verification
Two events can fall on the same clock edge: the last slot of one period, and the acceptance and load of the next sample. The bench provokes this by holding `in_valid` high through a whole period with the next sample already on the inputs. It checks that `in_ready` rises exactly in the final slot, and that the next word's strobe and first bit follow with no gap. A second case changes the configuration on the edge right after acceptance. The whole captured word must still match the configuration that was in force when the sample was taken.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

    localparam int SMP_W    = 22;
    localparam int GAIN_W   = 8;
    localparam int RND_W    = 15;
    localparam int DROP_W   = SMP_W - RND_W;
    localparam int WIDE_W   = SMP_W + 2 + GAIN_W;
    localparam int NARROW_W = RND_W + 1;
    localparam int WORD_MAX = 2 * WIDE_W;
    localparam int IDX_W    = $clog2(WORD_MAX);
    localparam int RATE_W   = 2;
    localparam int CNT_W    = IDX_W + (1 << RATE_W);
    localparam int LANES    = 2;

    typedef struct packed {
        logic              fmt15;
        logic              one_lane;
        logic              lsb_first;
        logic              q_first;
        logic              long_strobe;
        logic [RATE_W-1:0] rate;
    } cfg_t;

    typedef struct packed {
        logic [SMP_W-1:0]  i;
        logic [SMP_W-1:0]  q;
        logic [GAIN_W-1:0] gain;
        logic              gchg;
    } smp_t;

    typedef struct packed {
        logic [WORD_MAX-1:0] w0;
        logic [WORD_MAX-1:0] w1;
        logic [IDX_W:0]      len;
    } frame_t;

    function automatic logic [RND_W-1:0] round_sat(input logic [SMP_W-1:0] x);
        logic [RND_W-1:0] hi;
        hi = x[SMP_W-1:DROP_W];
        if (x[DROP_W-1] && (hi != {1'b0, {(RND_W-1){1'b1}}}))
            hi = hi + RND_W'(1);
        return hi;
    endfunction

    function automatic logic [WIDE_W-1:0] pack_wide(input logic [SMP_W-1:0] x,
                                                    input logic gchg,
                                                    input logic [GAIN_W-1:0] gain);
        return {x, 1'b0, gchg, gain};
    endfunction

    function automatic logic [NARROW_W-1:0] pack_narrow(input logic [SMP_W-1:0] x,
                                                        input logic gchg);
        return {round_sat(x), gchg};
    endfunction

    function automatic logic [IDX_W:0] word_len(input logic fmt15, input logic one_lane);
        logic [IDX_W:0] half;
        half = fmt15 ? (IDX_W+1)'(NARROW_W) : (IDX_W+1)'(WIDE_W);
        return one_lane ? (IDX_W+1)'(half << 1) : half;
    endfunction

endpackage

// File: rtl/rxp_word_build.sv
module rxp_word_build
    import rxp_pkg::*;
(
    input  cfg_t   cfg,
    input  smp_t   smp,
    output frame_t frame
);
    logic [SMP_W-1:0] first_s;
    logic [SMP_W-1:0] second_s;

    always_comb begin
        first_s   = cfg.q_first ? smp.q : smp.i;
        second_s  = cfg.q_first ? smp.i : smp.q;
        frame.w0  = '0;
        frame.w1  = '0;
        frame.len = word_len(cfg.fmt15, cfg.one_lane);
        if (!cfg.fmt15) begin
            if (cfg.one_lane) begin
                frame.w0 = {pack_wide(first_s, smp.gchg, smp.gain),
                            pack_wide(second_s, smp.gchg, smp.gain)};
            end else begin
                frame.w0 = WORD_MAX'(pack_wide(smp.i, smp.gchg, smp.gain));
                frame.w1 = WORD_MAX'(pack_wide(smp.q, smp.gchg, smp.gain));
            end
        end else begin
            if (cfg.one_lane) begin
                frame.w0 = WORD_MAX'({pack_narrow(first_s, smp.gchg),
                                      pack_narrow(second_s, smp.gchg)});
            end else begin
                frame.w0 = WORD_MAX'(pack_narrow(smp.i, smp.gchg));
                frame.w1 = WORD_MAX'(pack_narrow(smp.q, smp.gchg));
            end
        end
    end
endmodule

// File: rtl/rxp_slot_timer.sv
module rxp_slot_timer
    import rxp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [CNT_W-1:0] period,
    output logic             busy,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    assign last = busy && (cnt == period - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (last) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            cnt  <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/rxp_lane_out.sv
module rxp_lane_out
    import rxp_pkg::*;
(
    input  logic [WORD_MAX-1:0] word,
    input  logic [IDX_W:0]      len,
    input  logic [CNT_W-1:0]    cnt,
    input  logic                busy,
    input  logic                lsb_first,
    input  logic                enable,
    output logic                bit_o
);
    logic             live;
    logic [IDX_W-1:0] pos;

    always_comb begin
        live  = enable && busy && (cnt < CNT_W'(len));
        pos   = lsb_first ? cnt[IDX_W-1:0]
                          : IDX_W'(len[IDX_W-1:0] - IDX_W'(1) - cnt[IDX_W-1:0]);
        bit_o = live && word[pos];
    end
endmodule

// File: rtl/rx_ssi_packer.sv
module rx_ssi_packer
    import rxp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_fmt15,
    input  logic              cfg_one_lane,
    input  logic              cfg_lsb_first,
    input  logic              cfg_q_first,
    input  logic              cfg_long_strobe,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [SMP_W-1:0]  in_i,
    input  logic [SMP_W-1:0]  in_q,
    input  logic [GAIN_W-1:0] in_gain,
    input  logic              in_gain_chg,
    output logic              ser_dclk,
    output logic              ser_strobe,
    output logic              ser_d0,
    output logic              ser_d1
);
    cfg_t             cfg_in;
    cfg_t             cfg_q;
    smp_t             smp_in;
    frame_t           frame_nx;
    frame_t           frame_q;
    logic             accept;
    logic             busy;
    logic             last;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] period;
    logic [LANES-1:0] lane_bits;

    assign cfg_in = '{fmt15: cfg_fmt15, one_lane: cfg_one_lane, lsb_first: cfg_lsb_first,
                      q_first: cfg_q_first, long_strobe: cfg_long_strobe, rate: cfg_rate};
    assign smp_in = '{i: in_i, q: in_q, gain: in_gain, gchg: in_gain_chg};

    assign period   = CNT_W'(frame_q.len) << cfg_q.rate;
    assign in_ready = !busy || last;
    assign accept   = in_valid && in_ready;

    rxp_word_build i_build (
        .cfg   (cfg_in),
        .smp   (smp_in),
        .frame (frame_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            frame_q <= '0;
        end else if (accept) begin
            cfg_q   <= cfg_in;
            frame_q <= frame_nx;
        end
    end

    rxp_slot_timer i_timer (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .period (period),
        .busy   (busy),
        .cnt    (cnt),
        .last   (last)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rxp_lane_out i_lane (
            .word      ((g == 0) ? frame_q.w0 : frame_q.w1),
            .len       (frame_q.len),
            .cnt       (cnt),
            .busy      (busy),
            .lsb_first (cfg_q.lsb_first),
            .enable    ((g == 0) || !cfg_q.one_lane),
            .bit_o     (lane_bits[g])
        );
    end

    assign ser_d0 = lane_bits[0];
    assign ser_d1 = lane_bits[1];

    always_comb begin
        if (!busy)
            ser_strobe = 1'b0;
        else if (cfg_q.long_strobe)
            ser_strobe = cnt < CNT_W'(frame_q.len >> 1);
        else
            ser_strobe = (cnt == '0);
    end

    assign ser_dclk = clk;
endmodule

// File: rtl/rxp_chk.sv
module rxp_chk
    import rxp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] period,
    input logic [IDX_W:0]   len,
    input cfg_t             cfg_q,
    input logic             in_ready,
    input logic             ser_strobe,
    input logic             ser_d0,
    input logic             ser_d1
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ser_d0 && !ser_d1 && !ser_strobe)); // R9

    AST_ONE_LANE_Q_SILENT: assert property (@(posedge clk) disable iff (rst)
        (busy && cfg_q.one_lane) |-> !ser_d1); // R10

    AST_SHORT_STROBE_ONE_SLOT: assert property (@(posedge clk) disable iff (rst)
        (busy && !cfg_q.long_strobe && cnt != '0) |-> !ser_strobe); // R6

    AST_TAIL_SILENT: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt >= CNT_W'(len)) |-> (!ser_d0 && !ser_d1 && !ser_strobe)); // R7

    AST_READY_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
        (busy && in_ready) |-> (cnt == period - CNT_W'(1))); // R8

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != period - CNT_W'(1)) |=> (busy && cnt == $past(cnt) + CNT_W'(1))); // R7

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != period - CNT_W'(1)) |=> $stable(cfg_q)); // R11
endmodule

bind rx_ssi_packer rxp_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .cnt        (cnt),
    .period     (period),
    .len        (frame_q.len),
    .cfg_q      (cfg_q),
    .in_ready   (in_ready),
    .ser_strobe (ser_strobe),
    .ser_d0     (ser_d0),
    .ser_d1     (ser_d1)
);

// File: tb/test_rx_ssi_packer.sv
module test_rx_ssi_packer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        c_fmt15 = 0, c_one = 0, c_lsb = 0, c_qf = 0, c_long = 0;
    logic [1:0]  c_rate = 0;
    logic        in_valid = 0;
    logic        in_ready;
    logic [21:0] in_i = 0, in_q = 0;
    logic [7:0]  in_gain = 0;
    logic        in_gain_chg = 0;
    logic        ser_dclk, ser_strobe, ser_d0, ser_d1;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    int unsigned seed = 32'd1234;

    logic        e_fmt15, e_one, e_lsb, e_qf, e_long;
    logic [1:0]  e_rate;
    logic [21:0] e_i, e_q;
    logic [7:0]  e_gain;
    logic        e_gc;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_ssi_packer i_rx_ssi_packer (
        .clk(clk), .rst(rst),
        .cfg_fmt15(c_fmt15), .cfg_one_lane(c_one), .cfg_lsb_first(c_lsb),
        .cfg_q_first(c_qf), .cfg_long_strobe(c_long), .cfg_rate(c_rate),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_i(in_i), .in_q(in_q), .in_gain(in_gain), .in_gain_chg(in_gain_chg),
        .ser_dclk(ser_dclk), .ser_strobe(ser_strobe), .ser_d0(ser_d0), .ser_d1(ser_d1)
    );

    task automatic chk(input bit ok, input string what, input logic [511:0] act,
                       input logic [511:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [14:0] ref_rnd(input logic [21:0] x);
        logic [14:0] t;
        t = x[21:7];
        if (x[6] && t != 15'h3FFF) t = t + 15'd1;
        return t;
    endfunction

    task automatic snapshot();
        e_fmt15 = c_fmt15; e_one = c_one; e_lsb = c_lsb; e_qf = c_qf;
        e_long = c_long; e_rate = c_rate;
        e_i = in_i; e_q = in_q; e_gain = in_gain; e_gc = in_gain_chg;
    endtask

    task automatic ref_pack(output logic [63:0] w0, output logic [63:0] w1, output int len);
        logic [31:0] a, b;
        logic [15:0] c, d;
        a = {e_i, 1'b0, e_gc, e_gain};
        b = {e_q, 1'b0, e_gc, e_gain};
        c = {ref_rnd(e_i), e_gc};
        d = {ref_rnd(e_q), e_gc};
        w1 = '0;
        if (!e_fmt15) begin
            if (e_one) begin len = 64; w0 = e_qf ? {b, a} : {a, b}; end
            else begin len = 32; w0 = {32'b0, a}; w1 = {32'b0, b}; end
        end else begin
            if (e_one) begin len = 32; w0 = {32'b0, (e_qf ? {d, c} : {c, d})}; end
            else begin len = 16; w0 = {48'b0, c}; w1 = {48'b0, d}; end
        end
    endtask

    function automatic string mode_tag();
        string s;
        s = e_fmt15 ? "R4 R3" : (e_one ? "R2" : "R1");
        if (e_lsb) s = {s, " R5"};
        if (e_rate != 0) s = {s, " R7"};
        return s;
    endfunction

    // Called at the negedge holding slot 0 of the word described by e_*.
    task automatic check_word(input string extra);
        logic [511:0] c0, c1, cs, x0, x1, xs;
        logic [63:0] w0, w1;
        int len, per;
        string tag;
        ref_pack(w0, w1, len);
        per = len << e_rate;
        tag = {mode_tag(), extra};
        c0 = '0; c1 = '0; cs = '0; x0 = '0; x1 = '0; xs = '0;
        for (int k = 0; k < per; k++) begin
            c0[k] = ser_d0; c1[k] = ser_d1; cs[k] = ser_strobe;
            if (k < len) begin
                x0[k] = e_lsb ? w0[k] : w0[len-1-k];
                x1[k] = e_one ? 1'b0 : (e_lsb ? w1[k] : w1[len-1-k]);
            end
            xs[k] = e_long ? (k < len/2) : (k == 0);
            @(negedge clk);
        end
        chk(c0 === x0, {tag, " lane0"}, c0, x0);
        chk(c1 === x1, {tag, e_one ? " R10 lane1" : " lane1"}, c1, x1);
        chk(cs === xs, {tag, " R6 strobe"}, cs, xs);
    endtask

    task automatic send_one(input string extra, input bit flip);
        in_valid = 1'b1;
        snapshot();
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (flip) begin
            c_fmt15 = ~c_fmt15; c_one = ~c_one; c_lsb = ~c_lsb;
            c_qf = ~c_qf; c_long = ~c_long; c_rate = c_rate + 2'd1;
        end
        check_word(flip ? {extra, " R11"} : extra);
        chk({ser_d0, ser_d1, ser_strobe, in_ready} === 4'b0001, "R9 idle after word",
            512'({ser_d0, ser_d1, ser_strobe, in_ready}), 512'(4'b0001));
    endtask

    task automatic set_cfg(input logic f, input logic o, input logic l, input logic q,
                           input logic s, input logic [1:0] r);
        c_fmt15 = f; c_one = o; c_lsb = l; c_qf = q; c_long = s; c_rate = r;
    endtask

    task automatic set_smp(input logic [21:0] i, input logic [21:0] q,
                           input logic [7:0] g, input logic gc);
        in_i = i; in_q = q; in_gain = g; in_gain_chg = gc;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int ready_at;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 / R8: reset state
        chk({ser_d0, ser_d1, ser_strobe, in_ready} === 4'b0001, "R9 R8 reset state",
            512'({ser_d0, ser_d1, ser_strobe, in_ready}), 512'(4'b0001));

        // Directed formats
        set_cfg(0, 0, 0, 0, 0, 0); set_smp(22'h2ABCDE, 22'h155321, 8'hA5, 1'b1);
        send_one(" dir", 0);
        set_cfg(0, 1, 0, 1, 1, 0); set_smp(22'h012345, 22'h3FEDCB, 8'h3C, 1'b0);
        send_one(" dir", 0);
        set_cfg(0, 1, 1, 0, 0, 1); set_smp(22'h0F0F0F, 22'h30C30C, 8'h81, 1'b1);
        send_one(" dir", 0);
        // R3 saturation and round-up on both halves
        set_cfg(1, 1, 0, 0, 0, 0); set_smp(22'h1FFFC0, 22'h00007F, 8'h00, 1'b1);
        send_one(" R3 sat", 0);
        set_cfg(1, 0, 0, 0, 1, 3); set_smp(22'h1FFFBF, 22'h3FFFC0, 8'h00, 1'b0);
        send_one(" R3 edge", 0);
        // R11: config flipped during the word
        set_cfg(0, 0, 0, 0, 1, 2); set_smp(22'h1A2B3C, 22'h0C0FFE, 8'h5A, 1'b1);
        send_one(" cfgchg", 1);

        // R8: back-to-back, ready in last slot only, no gap
        set_cfg(1, 0, 0, 0, 0, 1); set_smp(22'h111111, 22'h222222, 8'h11, 1'b0);
        in_valid = 1'b1;
        @(negedge clk);
        set_smp(22'h2D2D2D, 22'h123456, 8'h77, 1'b1);
        ready_at = 0;
        while (!in_ready && ready_at < 1000) begin
            @(negedge clk);
            ready_at++;
        end
        chk(ready_at == 31, "R8 ready in last slot", 512'(ready_at), 512'(31));
        snapshot();
        @(negedge clk);
        in_valid = 1'b0;
        check_word(" R8 back-to-back");

        // Constrained random
        for (int n = 0; n < 40; n++) begin
            set_cfg(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                    1'($urandom), 2'($urandom));
            set_smp(22'($urandom), 22'($urandom), 8'($urandom), 1'($urandom));
            send_one(" rnd", ($urandom % 5) == 0);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule